// File: doc/BRIEF.md
# Masked time-of-day alarm comparator

This block watches a running BCD clock (minutes, hours, day of week, seconds and hundredths) and compares it against three programmable alarm registers. Each alarm register carries a mask bit in bit 7 and a compare value in bits 6:0. Together the three mask bits select how fine the match must be: a tick every minute, a minutes match, an hours-and-minutes match or a full day, hour and minute match. Mask patterns outside these four never raise the alarm.

The comparison is taken once per minute, in the single cycle in which hundredths first reads 0x99 while seconds reads 0x00. A match sets a sticky alarm flag. The flag holds until a clear pulse arrives. An active-low interrupt is asserted while the flag is set and the interrupt enable is on. The block does not count time, control an oscillator or decode a bus. The time values come in as plain inputs, and the registers are loaded through a simple write strobe.

Top module: `tod_alarm_match`

## Requirements
- R1: After reset, flag_o is 0 and irq_no is 1. All alarm registers and the interrupt enable reset to 0.
- R2: Register writes use wr_sel_i: 0 selects the minutes alarm, 1 the hours alarm, 2 the day alarm and 3 the control register, whose bit 0 is the interrupt enable. In an alarm register, bit 7 is the mask and bits 6:0 are the compare value. A write takes effect at the next clock edge.
- R3: With the mask bits (minutes, hours, day) = (1,1,1), every evaluation sets the flag, whatever the time values are.
- R4: With masks (0,1,1), an evaluation sets the flag only when cur_min_i[6:0] equals the minutes compare value.
- R5: With masks (0,0,1), the flag is set only when both minutes and hours match. The hours compare covers bits 6:0, so the 12/24 select (bit 6) and the AM/PM or second tens-of-hours bit (bit 5) must also match.
- R6: With masks (0,0,0), the flag is set only when minutes, hours and day (bits 6:0) all match.
- R7: The mask patterns (0,1,0), (1,0,0), (1,0,1) and (1,1,0) never set the flag.
- R8: An evaluation happens only in the cycle where hund_i equals 0x99, the previous cycle's hund_i was not 0x99, and sec_i equals 0x00. If hundredths stays at 0x99, or seconds is not 0x00, no new evaluation happens.
- R9: The flag is sticky and is cleared by clr_i. If a setting evaluation and clr_i occur in the same cycle, the flag is set.
- R10: irq_no is 0 exactly when the flag is set and the interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select (R2) |
| wr_data_i | input | 8 | Write data |
| cur_min_i | input | 8 | Current BCD minutes |
| cur_hour_i | input | 8 | Current hours in the time-register encoding |
| cur_day_i | input | 8 | Current BCD day of week |
| sec_i | input | 8 | Current BCD seconds |
| hund_i | input | 8 | Current BCD hundredths |
| clr_i | input | 1 | Flag clear pulse |
| flag_o | output | 1 | Sticky alarm flag |
| irq_no | output | 1 | Active-low interrupt |

## Verification
Any wrong stored mask bit, compare value or mode decode shows up on flag_o one cycle after the next evaluation window. It cannot be seen earlier, because nothing reaches the ports between windows. A broken window edge detector shows up as an extra or missing flag on the cycle after hundredths reaches 0x99. A bad enable bit shows up on irq_no in the same cycle as the write's clock edge. The bench sweeps every mask pattern against every combination of matching and mismatching fields, so each decode error appears within one window.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned N_FIELDS = 3;  // 0 minutes, 1 hours, 2 day
  localparam int unsigned FLD_MIN  = 0;
  localparam int unsigned FLD_HOUR = 1;
  localparam int unsigned FLD_DAY  = 2;

  typedef struct packed {
    logic       valid;
    logic [2:0] need;  // per field, indexed as FLD_*
  } mode_t;

  // msk indexed by FLD_*; pattern read as {min, hour, day}
  function automatic mode_t decode_mode(input logic [2:0] msk);
    mode_t m;
    m = '0;
    unique case ({msk[FLD_MIN], msk[FLD_HOUR], msk[FLD_DAY]})
      3'b111: begin m.valid = 1'b1; m.need = 3'b000; end
      3'b011: begin m.valid = 1'b1; m.need = 3'b001; end
      3'b001: begin m.valid = 1'b1; m.need = 3'b011; end
      3'b000: begin m.valid = 1'b1; m.need = 3'b111; end
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs #(
  parameter int unsigned NUM   = 3,
  parameter int unsigned DW    = 8,
  parameter int unsigned SEL_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [SEL_W-1:0]        wr_sel_i,
  input  logic [DW-1:0]           wr_data_i,
  output logic [NUM-1:0][DW-1:0]  alarm_o,
  output logic                    ien_o
);
  for (genvar i = 0; i < NUM; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      alarm_o[i] <= '0;
      else if (wr_en_i && wr_sel_i == SEL_W'(i))        alarm_o[i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        ien_o <= 1'b0;
    else if (wr_en_i && wr_sel_i == SEL_W'(NUM))        ien_o <= wr_data_i[0];
  end
endmodule

// File: rtl/tod_field_match.sv
module tod_field_match #(
  parameter int unsigned NUM   = 3,
  parameter int unsigned DW    = 8,
  parameter int unsigned CMP_W = 7
) (
  input  logic [NUM-1:0][DW-1:0] alarm_i,
  input  logic [NUM-1:0][DW-1:0] cur_i,
  output logic [NUM-1:0]         match_o,
  output logic [NUM-1:0]         mask_o
);
  for (genvar i = 0; i < NUM; i++) begin : g_cmp
    assign match_o[i] = (alarm_i[i][CMP_W-1:0] == cur_i[i][CMP_W-1:0]);
    assign mask_o[i]  = alarm_i[i][DW-1];
  end
endmodule

// File: rtl/tod_window_detect.sv
module tod_window_detect #(
  parameter int unsigned DW      = 8,
  parameter logic [7:0]  WIN_VAL = 8'h99,
  parameter logic [7:0]  SEC_VAL = 8'h00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] hund_i,
  input  logic [DW-1:0] sec_i,
  output logic          eval_o
);
  logic in_win, in_win_q;
  assign in_win = (hund_i == DW'(WIN_VAL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_win_q <= 1'b0;
    else         in_win_q <= in_win;
  end

  // first cycle of the window only
  assign eval_o = in_win && !in_win_q && (sec_i == DW'(SEC_VAL));
endmodule

// File: rtl/tod_flag_ctrl.sv
module tod_flag_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ien_i,
  output logic flag_o,
  output logic irq_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;  // set wins over clear
    else if (clr_i)  flag_o <= 1'b0;
  end

  assign irq_no = ~(flag_o & ien_i);
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
#(
  parameter int unsigned DW      = DATA_W,
  parameter int unsigned CMP_W   = DW - 1,
  parameter logic [7:0]  WIN_VAL = 8'h99,
  parameter logic [7:0]  SEC_VAL = 8'h00,
  localparam int unsigned SEL_W  = $clog2(N_FIELDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [DW-1:0]    cur_min_i,
  input  logic [DW-1:0]    cur_hour_i,
  input  logic [DW-1:0]    cur_day_i,
  input  logic [DW-1:0]    sec_i,
  input  logic [DW-1:0]    hund_i,
  input  logic             clr_i,
  output logic             flag_o,
  output logic             irq_no
);
  logic [N_FIELDS-1:0][DW-1:0] alarm, cur;
  logic [N_FIELDS-1:0]         match, mask;
  logic                        ien, eval, fire;
  mode_t                       mode;

  assign cur[FLD_MIN]  = cur_min_i;
  assign cur[FLD_HOUR] = cur_hour_i;
  assign cur[FLD_DAY]  = cur_day_i;

  tod_alarm_regs #(.NUM(N_FIELDS), .DW(DW), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .alarm_o(alarm), .ien_o(ien)
  );

  tod_field_match #(.NUM(N_FIELDS), .DW(DW), .CMP_W(CMP_W)) u_match (
    .alarm_i(alarm), .cur_i(cur), .match_o(match), .mask_o(mask)
  );

  tod_window_detect #(.DW(DW), .WIN_VAL(WIN_VAL), .SEC_VAL(SEC_VAL)) u_win (
    .clk_i, .rst_ni, .hund_i, .sec_i, .eval_o(eval)
  );

  assign mode = decode_mode(mask);
  assign fire = eval && mode.valid && ((match | ~mode.need) == '1);

  tod_flag_ctrl u_flag (
    .clk_i, .rst_ni, .set_i(fire), .clr_i, .ien_i(ien),
    .flag_o, .irq_no
  );
endmodule

// File: rtl/tod_alarm_match_chk.sv
module tod_alarm_match_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] hund_i,
  input logic [7:0] sec_i,
  input logic       clr_i,
  input logic       flag_o,
  input logic       irq_no,
  input logic [2:0] mask
);
  // R1
  always @(negedge clk_i)
    if (!rst_ni) a_r1_reset: assert (!flag_o && irq_no);

  a_r8_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> ($past(hund_i) == 8'h99 && $past(sec_i) == 8'h00));

  a_r7_undef_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> ($past(mask) inside {3'b111, 3'b110, 3'b100, 3'b000}));

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);

  a_r9_clear_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(clr_i));

  a_r10_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> flag_o);
endmodule

bind tod_alarm_match tod_alarm_match_chk u_chk (
  .clk_i, .rst_ni, .hund_i, .sec_i, .clr_i, .flag_o, .irq_no, .mask(mask)
);

// File: tb/tod_alarm_match_tb_top.sv
`timescale 1ns/1ps
module tod_alarm_match_tb_top;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, clr_i = 1'b0;
  logic [1:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0, cur_min_i = '0, cur_hour_i = '0, cur_day_i = '0;
  logic [7:0] sec_i = '0, hund_i = '0;
  logic       flag_o, irq_no;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  tod_alarm_match dut_i (.*);

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 0;
  endtask

  task automatic clear();
    @(negedge clk_i); clr_i = 1;
    @(negedge clk_i); clr_i = 0;
  endtask

  // one window; flag sampled at the negedge after the evaluating edge
  task automatic window(input logic [7:0] sec);
    @(negedge clk_i); hund_i = 8'h98; sec_i = sec;
    @(negedge clk_i); hund_i = 8'h99;
    @(negedge clk_i); hund_i = 8'h00;
  endtask

  function automatic logic expect_fire(input logic [2:0] m, input logic [2:0] p);
    // m, p as {min, hour, day}
    case (m)
      3'b111: return 1'b1;
      3'b011: return p[2];
      3'b001: return p[2] & p[1];
      3'b000: return &p;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check(flag_o, 1'b0, "R1 flag reset");
    check(irq_no, 1'b1, "R1 irq reset");
    rst_ni = 1;
    // reset alarm regs: full mode, day 0 never matches a day of 1..7
    cur_day_i = 8'h03;
    window(8'h00);
    check(flag_o, 1'b0, "R1 reset regs no fire");

    // R3 R4 R5 R6 R7 R2: full sweep of masks x match patterns
    for (int m = 0; m < 8; m++) begin
      wr(2'd0, {m[2], 7'h30});
      wr(2'd1, {m[1], 7'h72});   // 12h mode, PM, 12
      wr(2'd2, {m[0], 7'h05});
      for (int p = 0; p < 8; p++) begin
        clear();
        cur_min_i  = p[2] ? 8'h30 : 8'h31;
        cur_hour_i = p[1] ? 8'h72 : 8'h52;  // differs only in AM/PM bit
        cur_day_i  = p[0] ? 8'h05 : 8'h06;
        window(8'h00);
        check(flag_o, expect_fire(m[2:0], p[2:0]),
              $sformatf("R3-R7 sweep(R2 R5) mask=%03b pat=%03b", m[2:0], p[2:0]));
      end
    end

    // R8: seconds not 00 -> no evaluation
    wr(2'd0, 8'h80); wr(2'd1, 8'h80); wr(2'd2, 8'h80);
    clear();
    window(8'h01);
    check(flag_o, 1'b0, "R8 sec not zero");
    window(8'h00);
    check(flag_o, 1'b1, "R8 sec zero fires");

    // R8: hundredths held at 99 evaluates only once
    @(negedge clk_i); hund_i = 8'h99;
    @(negedge clk_i);
    clr_i = 1;
    @(negedge clk_i); clr_i = 0;
    @(negedge clk_i); @(negedge clk_i);
    check(flag_o, 1'b0, "R8 held window no refire");
    hund_i = 8'h00;

    // R9: sticky across idle cycles
    window(8'h00);
    repeat (5) @(negedge clk_i);
    check(flag_o, 1'b1, "R9 sticky");
    // R9: set beats clear in the same cycle
    @(negedge clk_i); hund_i = 8'h98; sec_i = 8'h00;
    @(negedge clk_i); hund_i = 8'h99; clr_i = 1;
    @(negedge clk_i); hund_i = 8'h00; clr_i = 0;
    check(flag_o, 1'b1, "R9 set wins");
    clear();
    check(flag_o, 1'b0, "R9 cleared");

    // R10 irq gating
    window(8'h00);
    check(irq_no, 1'b1, "R10 irq disabled");
    wr(2'd3, 8'h01);
    check(irq_no, 1'b0, "R10 irq enabled");
    clear();
    check(irq_no, 1'b1, "R10 irq after clear");
    wr(2'd3, 8'h00);
    window(8'h00);
    check(irq_no, 1'b1, "R10 irq enable off again");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule